// File: doc/BRIEF.md
# Three-Wire Serial Tuner Control Register

This block is the serial control front end of a frequency synthesizer. A host moves words into it over three wires: an enable level, a serial clock and a data line. Bits are taken on falling serial-clock edges while the enable is high. When the enable drops, the block counts the bits it received and uses that count to decide which internal registers take the new word.

The registers hold a 4-bit band-switch field, a 15-bit divider, two ratio-select bits, a charge-pump current bit, a tuning-output disable bit and a 3-bit test code. Some fields load partway through a transfer, on a fixed rising serial-clock edge. Others load only when the enable falls. Fields that only the longest word carries keep their values across the two shorter formats. The block also decodes the reference-divider ratio from the two ratio-select bits.

All three serial wires are synchronized into the system clock domain. Each update of the divider or of the control group produces a one-cycle strobe.

Top module: `tuner_serial_ctrl`

## Requirements
- R1: After reset the outputs take these values:
  - band 0 and divider 0;
  - `rsa_o` = 1 and `rsb_o` = parameter `RSB_RESET` (default 1);
  - `cp_o` = 0 (low current);
  - `tune_off_o` = 1 (tuning output disabled);
  - `test_o` = 3'b000 (normal mode);
  - both strobes low.
- R2: Data is sampled only on falling serial-clock edges seen while the enable is high. Serial-clock activity with the enable low changes no register and raises no strobe. It also leaves no residue in the bit count of the next transfer.
- R3: Bit 1 is the first bit sent. Bits 1 to 4 form the band field, with bit 1 as `band_o[3]`. The band field loads on the 5th rising serial-clock edge of a transfer. It stays loaded whatever length the transfer later turns out to have.
- R4: An 18-bit transfer, when the enable falls, sets `divider_o` = {0, bits 5..18}, with bit 5 as divider bit 13. It also sets `rsa_o` = 1.
- R5: A 19-bit transfer, when the enable falls, sets `divider_o` = bits 5..19, with bit 5 as divider bit 14. It also sets `rsa_o` = 0.
- R6: In a 27-bit transfer, `divider_o` takes bits 5..19 on the 20th rising serial-clock edge, before the enable falls. When the enable falls, the control bits load as follows:
  - bit 20 sets `cp_o`;
  - bits 21..23 set `test_o[2:0]`, with bit 21 as `test_o[2]`;
  - bit 24 sets `rsa_o`;
  - bit 25 sets `rsb_o`;
  - bit 26 sets `tune_off_o`;
  - bit 27 is ignored.
- R7: 18-bit and 19-bit transfers leave `cp_o`, `test_o`, `rsb_o` and `tune_off_o` unchanged.
- R8: A transfer of fewer than 18 bits leaves `divider_o` and `rsa_o` unchanged and raises no strobe.
- R9: A transfer of 20 to 26 bits, or more than 27 bits, updates nothing when the enable falls. The divider load made on the 20th rising edge remains in effect.
- R10: `ref_ratio_o` is 640 whenever `rsb_o` = 0. It is 1024 when `rsa_o` = 0 and `rsb_o` = 1, and 512 when both are 1.
- R11: `freq_load_o` is high for exactly one cycle, in the cycle the new divider value first appears. `ctrl_load_o` is high for exactly one cycle, in the cycle new 27-bit control bits first appear.
- R12: A falling serial-clock edge that reaches the block in the same cycle as the enable falling is counted as a bit of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sen_i | input | 1 | Serial enable; a transfer lasts while it is high |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data, taken on falling sclk_i |
| band_o | output | 4 | Band-switch field |
| divider_o | output | 15 | Programmable divider value |
| rsa_o | output | 1 | Ratio select A |
| rsb_o | output | 1 | Ratio select B |
| cp_o | output | 1 | Charge-pump high-current select |
| tune_off_o | output | 1 | Tuning output disable |
| test_o | output | 3 | Test code, 0 = normal mode |
| ref_ratio_o | output | 11 | Reference divider ratio |
| freq_load_o | output | 1 | One-cycle strobe on a divider update |
| ctrl_load_o | output | 1 | One-cycle strobe on a control-group update |

## Verification
The last falling serial-clock edge of a word and the fall of the enable can land in the same synchronized cycle. In that case the bit shift and the length decode both act in one clock. The bench provokes this by switching `sclk_i` low and `sen_i` low at the same instant at the end of an 18-bit word. The previous divider value differs and the final bit is 1, so a decode that missed the merged bit would leave the divider as it was. The result counts as correct only if the divider holds the full 18-bit value, `rsa_o` is 1, and exactly one `freq_load_o` pulse was seen.

// File: rtl/tuner_serial_pkg.sv
package tuner_serial_pkg;

  // Control group carried only by the longest word
  localparam int CTRL_W  = 8;
  localparam int TEST_W  = 3;
  localparam int RATIO_W = 11;

  localparam logic [RATIO_W-1:0] RATIO_RSB_LOW = RATIO_W'(640);
  localparam logic [RATIO_W-1:0] RATIO_A_LOW   = RATIO_W'(1024);
  localparam logic [RATIO_W-1:0] RATIO_A_HIGH  = RATIO_W'(512);

  typedef struct packed {
    logic              cp;
    logic [TEST_W-1:0] test;
    logic              rsa;
    logic              rsb;
    logic              tune_off;
  } ctrl_t;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic rsa, input logic rsb);
    logic [RATIO_W-1:0] r;
    if (!rsb)     r = RATIO_RSB_LOW;
    else if (rsa) r = RATIO_A_HIGH;
    else          r = RATIO_A_LOW;
    return r;
  endfunction

endpackage

// File: rtl/tsr_front.sv
// Synchronizes the three serial wires and the reset release, and derives
// the qualified serial-clock edges and the enable fall.
module tsr_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_i,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic rst_core_n,
  output logic sen_act,
  output logic sdat_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sen_fall
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic [SYNC_STAGES-1:0] sen_pipe;
  logic [SYNC_STAGES-1:0] sclk_pipe;
  logic [SYNC_STAGES-1:0] sdat_pipe;
  logic                   sen_d;
  logic                   sclk_d;
  logic                   sen_s;
  logic                   sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe  <= '0;
      sen_pipe  <= '0;
      sclk_pipe <= '0;
      sdat_pipe <= '0;
      sen_d     <= 1'b0;
      sclk_d    <= 1'b0;
    end else begin
      rst_pipe[0]  <= 1'b1;
      sen_pipe[0]  <= sen_i;
      sclk_pipe[0] <= sclk_i;
      sdat_pipe[0] <= sdat_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        rst_pipe[k]  <= rst_pipe[k-1];
        sen_pipe[k]  <= sen_pipe[k-1];
        sclk_pipe[k] <= sclk_pipe[k-1];
        sdat_pipe[k] <= sdat_pipe[k-1];
      end
      sen_d  <= sen_pipe[LAST];
      sclk_d <= sclk_pipe[LAST];
    end
  end

  assign sen_s  = sen_pipe[LAST];
  assign sclk_s = sclk_pipe[LAST];
  assign sdat_s = sdat_pipe[LAST];

  // An edge counts when the enable was high in the cycle before it, so an
  // edge that coincides with the enable fall still belongs to the transfer.
  assign sen_act    = sen_d;
  assign sclk_rise  = sen_d & sclk_s & ~sclk_d;
  assign sclk_fall  = sen_d & ~sclk_s & sclk_d;
  assign sen_fall   = sen_d & ~sen_s;
  assign rst_core_n = rst_pipe[LAST];

endmodule

// File: rtl/tsr_collect.sv
// Shift register and saturating bit counter. Exposes next-cycle values so the
// length decode at the enable fall sees a bit sampled in the same cycle.
module tsr_collect #(
  parameter int SHIFT_W = 15,
  parameter int CNT_W   = 5,
  parameter int BAND_W  = 4,
  parameter int DIV_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sen_act,
  input  logic               sdat_s,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [SHIFT_W-1:0] shift_nx,
  output logic [CNT_W-1:0]   cnt_nx,
  output logic               band_hit,
  output logic               div_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] BAND_CNT = CNT_W'(BAND_W);
  localparam logic [CNT_W-1:0] DIV_CNT  = CNT_W'(BAND_W + DIV_W);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    shift_nx = shift_q;
    cnt_nx   = cnt_q;
    if (!sen_act) begin
      shift_nx = '0;
      cnt_nx   = '0;
    end else if (sclk_fall) begin
      shift_nx = {shift_q[SHIFT_W-2:0], sdat_s};
      if (cnt_q != CNT_MAX) begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  // Rising edge k arrives after k-1 sampled bits
  assign band_hit = sclk_rise && (cnt_q == BAND_CNT);
  assign div_hit  = sclk_rise && (cnt_q == DIV_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_nx;
      cnt_q   <= cnt_nx;
    end
  end

endmodule

// File: rtl/tsr_regs.sv
// Register bank: band field, divider and control group, with load strobes.
module tsr_regs
  import tuner_serial_pkg::*;
#(
  parameter int   BAND_W    = 4,
  parameter int   DIV_W     = 15,
  parameter int   CNT_W     = 5,
  parameter logic RSB_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  shift_q,
  input  logic [DIV_W-1:0]  shift_nx,
  input  logic [CNT_W-1:0]  cnt_nx,
  input  logic              band_hit,
  input  logic              div_hit,
  input  logic              sen_fall,
  output logic [BAND_W-1:0] band_q,
  output logic [DIV_W-1:0]  div_q,
  output ctrl_t             ctrl_q,
  output logic              freq_load_q,
  output logic              ctrl_load_q
);

  localparam int LEN_LONG  = BAND_W + DIV_W;
  localparam int LEN_SHORT = LEN_LONG - 1;
  localparam int LEN_FULL  = LEN_LONG + CTRL_W;

  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(LEN_SHORT);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LEN_LONG);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(LEN_FULL);

  localparam ctrl_t CTRL_RESET = '{cp: 1'b0, test: '0, rsa: 1'b1,
                                   rsb: RSB_RESET, tune_off: 1'b1};

  logic [BAND_W-1:0] band_nx;
  logic [DIV_W-1:0]  div_nx;
  ctrl_t             ctrl_nx;
  logic              freq_load_nx;
  logic              ctrl_load_nx;
  logic [CTRL_W-1:0] ctrl_bits;

  assign ctrl_bits = shift_nx[CTRL_W-1:0];

  always_comb begin
    band_nx      = band_q;
    div_nx       = div_q;
    ctrl_nx      = ctrl_q;
    freq_load_nx = 1'b0;
    ctrl_load_nx = 1'b0;

    if (band_hit) begin
      band_nx = shift_q[BAND_W-1:0];
    end

    if (div_hit) begin
      div_nx       = shift_q;
      freq_load_nx = 1'b1;
    end

    if (sen_fall) begin
      case (cnt_nx)
        CNT_SHORT: begin
          div_nx       = {1'b0, shift_nx[DIV_W-2:0]};
          ctrl_nx.rsa  = 1'b1;
          freq_load_nx = 1'b1;
        end
        CNT_LONG: begin
          div_nx       = shift_nx;
          ctrl_nx.rsa  = 1'b0;
          freq_load_nx = 1'b1;
        end
        CNT_FULL: begin
          ctrl_nx.cp       = ctrl_bits[CTRL_W-1];
          ctrl_nx.test     = ctrl_bits[CTRL_W-2 -: TEST_W];
          ctrl_nx.rsa      = ctrl_bits[CTRL_W-2-TEST_W];
          ctrl_nx.rsb      = ctrl_bits[CTRL_W-3-TEST_W];
          ctrl_nx.tune_off = ctrl_bits[CTRL_W-4-TEST_W];
          ctrl_load_nx     = 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q      <= '0;
      div_q       <= '0;
      ctrl_q      <= CTRL_RESET;
      freq_load_q <= 1'b0;
      ctrl_load_q <= 1'b0;
    end else begin
      band_q      <= band_nx;
      div_q       <= div_nx;
      ctrl_q      <= ctrl_nx;
      freq_load_q <= freq_load_nx;
      ctrl_load_q <= ctrl_load_nx;
    end
  end

endmodule

// File: rtl/tsr_ratio.sv
// Reference-divider ratio decode from the two select bits.
module tsr_ratio
  import tuner_serial_pkg::*;
(
  input  logic               rsa,
  input  logic               rsb,
  output logic [RATIO_W-1:0] ratio
);

  always_comb begin
    ratio = ratio_of(rsa, rsb);
  end

endmodule

// File: rtl/tuner_serial_ctrl.sv
module tuner_serial_ctrl
  import tuner_serial_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter int   BAND_W      = 4,
  parameter int   DIV_W       = 15,
  parameter logic RSB_RESET   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sen_i,
  input  logic               sclk_i,
  input  logic               sdat_i,
  output logic [BAND_W-1:0]  band_o,
  output logic [DIV_W-1:0]   divider_o,
  output logic               rsa_o,
  output logic               rsb_o,
  output logic               cp_o,
  output logic               tune_off_o,
  output logic [TEST_W-1:0]  test_o,
  output logic [RATIO_W-1:0] ref_ratio_o,
  output logic               freq_load_o,
  output logic               ctrl_load_o
);

  localparam int WORD_FULL = BAND_W + DIV_W + CTRL_W;
  localparam int CNT_W     = $clog2(WORD_FULL + 2);

  logic             rst_core_n;
  logic             sen_act;
  logic             sdat_s;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             sen_fall;
  logic [DIV_W-1:0] shift_q;
  logic [DIV_W-1:0] shift_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             band_hit;
  logic             div_hit;
  ctrl_t            ctrl_q;

  tsr_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_i     (sen_i),
    .sclk_i    (sclk_i),
    .sdat_i    (sdat_i),
    .rst_core_n(rst_core_n),
    .sen_act   (sen_act),
    .sdat_s    (sdat_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sen_fall  (sen_fall)
  );

  tsr_collect #(
    .SHIFT_W(DIV_W),
    .CNT_W  (CNT_W),
    .BAND_W (BAND_W),
    .DIV_W  (DIV_W)
  ) u_collect (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sen_act  (sen_act),
    .sdat_s   (sdat_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .shift_q  (shift_q),
    .shift_nx (shift_nx),
    .cnt_nx   (cnt_nx),
    .band_hit (band_hit),
    .div_hit  (div_hit)
  );

  tsr_regs #(
    .BAND_W   (BAND_W),
    .DIV_W    (DIV_W),
    .CNT_W    (CNT_W),
    .RSB_RESET(RSB_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .shift_q    (shift_q),
    .shift_nx   (shift_nx),
    .cnt_nx     (cnt_nx),
    .band_hit   (band_hit),
    .div_hit    (div_hit),
    .sen_fall   (sen_fall),
    .band_q     (band_o),
    .div_q      (divider_o),
    .ctrl_q     (ctrl_q),
    .freq_load_q(freq_load_o),
    .ctrl_load_q(ctrl_load_o)
  );

  tsr_ratio u_ratio (
    .rsa  (ctrl_q.rsa),
    .rsb  (ctrl_q.rsb),
    .ratio(ref_ratio_o)
  );

  assign rsa_o      = ctrl_q.rsa;
  assign rsb_o      = ctrl_q.rsb;
  assign cp_o       = ctrl_q.cp;
  assign tune_off_o = ctrl_q.tune_off;
  assign test_o     = ctrl_q.test;

endmodule

// File: rtl/tuner_serial_ctrl_chk.sv
module tuner_serial_ctrl_chk
  import tuner_serial_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DIV_W-1:0]   divider_o,
  input logic               rsa_o,
  input logic               rsb_o,
  input logic               cp_o,
  input logic               tune_off_o,
  input logic [TEST_W-1:0]  test_o,
  input logic [RATIO_W-1:0] ref_ratio_o,
  input logic               freq_load_o,
  input logic               ctrl_load_o
);

  a_r11_freq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load_o |=> !freq_load_o);

  a_r11_ctrl_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load_o |=> !ctrl_load_o);

  a_r7_ctrl_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cp_o, test_o, rsb_o, tune_off_o}) |-> ctrl_load_o);

  a_r8_div_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divider_o) |-> freq_load_o);

  a_r4_rsa_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsa_o) |-> (freq_load_o || ctrl_load_o));

  a_r10_ratio_rsb_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rsb_o |-> (ref_ratio_o == RATIO_W'(640)));

  a_r10_ratio_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rsb_o && !rsa_o) |-> (ref_ratio_o == RATIO_W'(1024)));

  a_r10_ratio_a_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rsb_o && rsa_o) |-> (ref_ratio_o == RATIO_W'(512)));

endmodule

bind tuner_serial_ctrl tuner_serial_ctrl_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/tuner_serial_ctrl_test.sv
`timescale 1ns/1ps
module tuner_serial_ctrl_test;

  localparam int HALF = 6;

  logic        clk;
  logic        rst_n;
  logic        sen_i;
  logic        sclk_i;
  logic        sdat_i;
  logic [3:0]  band_o;
  logic [14:0] divider_o;
  logic        rsa_o;
  logic        rsb_o;
  logic        cp_o;
  logic        tune_off_o;
  logic [2:0]  test_o;
  logic [10:0] ref_ratio_o;
  logic        freq_load_o;
  logic        ctrl_load_o;

  int checks;
  int failures;
  int fcnt;
  int ccnt;
  bit done;

  // expected state
  logic [3:0]  e_band;
  logic [14:0] e_div;
  logic        e_rsa, e_rsb, e_cp, e_off;
  logic [2:0]  e_test;

  // probe captured mid-transfer
  logic [14:0] p_div;
  int          p_fcnt;
  int          p_ccnt;
  logic        p_cp;

  tuner_serial_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sen_i      (sen_i),
    .sclk_i     (sclk_i),
    .sdat_i     (sdat_i),
    .band_o     (band_o),
    .divider_o  (divider_o),
    .rsa_o      (rsa_o),
    .rsb_o      (rsb_o),
    .cp_o       (cp_o),
    .tune_off_o (tune_off_o),
    .test_o     (test_o),
    .ref_ratio_o(ref_ratio_o),
    .freq_load_o(freq_load_o),
    .ctrl_load_o(ctrl_load_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n && freq_load_o) fcnt <= fcnt + 1;
    if (rst_n && ctrl_load_o) ccnt <= ccnt + 1;
  end

  function automatic logic [31:0] exp_ratio(input logic a, input logic b);
    if (!b)    return 32'd640;
    else if (a) return 32'd512;
    else        return 32'd1024;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, "band",     32'(band_o),      32'(e_band));
    check(req, "divider",  32'(divider_o),   32'(e_div));
    check(req, "rsa",      32'(rsa_o),       32'(e_rsa));
    check(req, "rsb",      32'(rsb_o),       32'(e_rsb));
    check(req, "cp",       32'(cp_o),        32'(e_cp));
    check(req, "tune_off", 32'(tune_off_o),  32'(e_off));
    check(req, "test",     32'(test_o),      32'(e_test));
    check("R10", "ratio",  32'(ref_ratio_o), exp_ratio(e_rsa, e_rsb));
  endtask

  // Bit 1 is w[n-1]. merge: final sclk fall and sen fall on the same edge.
  task automatic send_word(input logic [31:0] w, input int n,
                           input bit merge, input int probe);
    @(negedge clk);
    sen_i = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 1; i <= n; i++) begin
      sdat_i = w[n-i];
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i == probe) begin
        p_div  = divider_o;
        p_fcnt = fcnt;
        p_ccnt = ccnt;
        p_cp   = cp_o;
      end
      sclk_i = 1'b0;
      if (merge && i == n) sen_i = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sen_i = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    e_band = 4'h0; e_div = 15'h0; e_rsa = 1'b1; e_rsb = 1'b1;
    e_cp = 1'b0; e_off = 1'b1; e_test = 3'b000;
    check_state("R1");
    check("R1", "freq_load", 32'(freq_load_o), 32'd0);
    check("R1", "ctrl_load", 32'(ctrl_load_o), 32'd0);
  endtask

  task automatic t_word18();
    int f0 = fcnt, c0 = ccnt;
    send_word({14'h0, 4'hA, 14'h1234}, 18, 1'b0, 0);
    e_band = 4'hA; e_div = 15'h1234; e_rsa = 1'b1;
    check_state("R4");
    check("R3", "band after 18", 32'(band_o), 32'hA);
    check("R11", "freq strobes 18", 32'(fcnt - f0), 32'd1);
    check("R7", "ctrl strobes 18", 32'(ccnt - c0), 32'd0);
  endtask

  task automatic t_word19();
    int f0 = fcnt;
    send_word({13'h0, 4'h5, 15'h7ABC}, 19, 1'b0, 0);
    e_band = 4'h5; e_div = 15'h7ABC; e_rsa = 1'b0;
    check_state("R5");
    check("R10", "ratio 1024", 32'(ref_ratio_o), 32'd1024);
    check("R11", "freq strobes 19", 32'(fcnt - f0), 32'd1);
  endtask

  task automatic t_word27();
    int f0 = fcnt, c0 = ccnt;
    // control: cp=1 test=101 rsa=0 rsb=0 tune_off=0 spare=1
    send_word({5'h0, 4'h3, 15'h4321, 8'b1_101_0_0_0_1}, 27, 1'b0, 20);
    check("R6", "divider at 20th rise", 32'(p_div), 32'h4321);
    check("R6", "freq strobe by 20th rise", 32'(p_fcnt - f0), 32'd1);
    check("R6", "ctrl not yet at 20th rise", 32'(p_ccnt - c0), 32'd0);
    check("R6", "cp not yet at 20th rise", 32'(p_cp), 32'd0);
    e_band = 4'h3; e_div = 15'h4321; e_cp = 1'b1; e_test = 3'b101;
    e_rsa = 1'b0; e_rsb = 1'b0; e_off = 1'b0;
    check_state("R6");
    check("R10", "ratio 640", 32'(ref_ratio_o), 32'd640);
    check("R11", "ctrl strobes 27", 32'(ccnt - c0), 32'd1);
    check("R11", "freq strobes 27", 32'(fcnt - f0), 32'd1);
  endtask

  task automatic t_persist();
    int c0 = ccnt;
    send_word({14'h0, 4'h7, 14'h0055}, 18, 1'b0, 0);
    e_band = 4'h7; e_div = 15'h0055; e_rsa = 1'b1;
    check_state("R7");
    check("R10", "rsb low keeps 640", 32'(ref_ratio_o), 32'd640);
    check("R7", "no ctrl strobe", 32'(ccnt - c0), 32'd0);
  endtask

  task automatic t_short();
    int f0 = fcnt, c0 = ccnt;
    send_word({20'h0, 4'hC, 8'hFF}, 12, 1'b0, 0);
    e_band = 4'hC;
    check_state("R8");
    check("R3", "band from short word", 32'(band_o), 32'hC);
    check("R8", "no freq strobe", 32'(fcnt - f0), 32'd0);
    check("R8", "no ctrl strobe", 32'(ccnt - c0), 32'd0);
  endtask

  task automatic t_idle_clock();
    int f0 = fcnt, c0 = ccnt;
    sen_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      sdat_i = i[0];
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (4*HALF) @(negedge clk);
    check_state("R2");
    check("R2", "no strobes idle", 32'((fcnt - f0) + (ccnt - c0)), 32'd0);
    send_word({13'h0, 4'h2, 15'h1111}, 19, 1'b0, 0);
    e_band = 4'h2; e_div = 15'h1111; e_rsa = 1'b0;
    check_state("R2");
  endtask

  task automatic t_odd_len();
    int f0 = fcnt, c0 = ccnt;
    send_word({10'h0, 4'h9, 15'h0F0F, 3'b111}, 22, 1'b0, 0);
    e_band = 4'h9; e_div = 15'h0F0F;
    check_state("R9");
    check("R9", "only 20th-edge strobe", 32'(fcnt - f0), 32'd1);
    check("R9", "no ctrl strobe", 32'(ccnt - c0), 32'd0);
  endtask

  task automatic t_merge();
    int f0 = fcnt;
    send_word({14'h0, 4'h6, 14'h2001}, 18, 1'b1, 0);
    e_band = 4'h6; e_div = 15'h2001; e_rsa = 1'b1;
    check_state("R12");
    check("R12", "freq strobe merged", 32'(fcnt - f0), 32'd1);
  endtask

  initial begin
    checks = 0; failures = 0; fcnt = 0; ccnt = 0; done = 1'b0;
    rst_n = 1'b0; sen_i = 1'b0; sclk_i = 1'b0; sdat_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_word18();
    t_word19();
    t_word27();
    t_persist();
    t_short();
    t_idle_clock();
    t_odd_len();
    t_merge();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before all scenarios finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule